// File: doc/BRIEF.md
# Quad transceiver reset and ready sequencer

This block manages reset for a group of four serial transceiver channels. Three sources feed it: a power-up detect level, an active-low hardware reset pin that arrives asynchronously, and software reset bits that a host writes through a small register port. Each channel has its own reset output, and each has a ready flag that rises only after a settle interval. The interval is counted in clock cycles and starts again whenever any reset that covers the channel returns.

The sources differ in reach. Power-up and an accepted hardware reset clear every channel and also the host-visible registers. A software reset, whether for one channel or for the whole quad, holds only the channel logic in reset. The register contents stay as they were. The register port is a plain write strobe with a combinational read, and it has no back-pressure. Every pin of the block is a control or status level, so there is no streaming interface.

Top module: `xrc_rst_ctrl`

## Requirements
- R1: While `por_i` is high, every `ch_rst_o` bit is 1, every `ch_ready_o` bit is 0 and every register reads 0.
- R2: `hw_rst_n_i` passes through a two-flop synchronizer. A low level is accepted only after it has been seen for MIN_LOW (default 2) consecutive synchronized samples. A shorter low pulse changes no output and no register.
- R3: An accepted hardware reset holds all four channels in reset and clears every register. Writes have no effect while it is accepted.
- R4: The register at address c (0 to 3) is the configuration word of channel c. Its bit 2 holds channel c in reset while set, and the other channels are not affected.
- R5: The register at address 4 is the quad control word. Its bit 0 holds all four channels in reset while set.
- R6: A software reset of either kind leaves every register value unchanged and readable, including the bits that are not reset bits.
- R7: `ch_ready_o[c]` rises on the SETTLE_CYC-th clock edge that sees no reset source covering channel c. `ch_rst_o[c]` falls on the first of those edges.
- R8: When reset sources overlap, the settle count starts only after the last of them is released. Any source that returns drops ready on the next edge and restarts the count.
- R9: A read from an address above 4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host and sequencing clock |
| por_i | input | 1 | Power-up detect, active high, asynchronous assert |
| hw_rst_n_i | input | 1 | Hardware reset pin, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ch_rst_o | output | 4 | Per-channel reset, active high |
| ch_ready_o | output | 4 | Per-channel ready after settle |

## Verification
The hardest cases to reach from the ports are the ones where sources overlap. One example is a per-channel bit written while the quad-wide bit is still set, or while a channel is partway through its settle count. In that case ready must wait for the later release. The stimulus drives the pin with a one-cycle pulse and with pulses of exactly two cycles, which sit on the acceptance boundary. It also stacks software writes in the middle of a settle interval. A behavioural model that is clocked in the same cycle predicts every output on every clock.

// File: rtl/xrc_pkg.sv
package xrc_pkg;
  localparam int XRC_NCH      = 4;
  localparam int XRC_DW       = 8;
  localparam int XRC_AW       = 3;
  localparam int XRC_SRST_BIT = 2;
  localparam int XRC_GLB_BIT  = 0;
  localparam int XRC_GLB_ADDR = XRC_NCH;
  typedef logic [XRC_DW-1:0] xrc_word_t;
  typedef logic [XRC_AW-1:0] xrc_addr_t;
endpackage

// File: rtl/xrc_pin_filter.sv
module xrc_pin_filter #(
  parameter int MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic hw_acc_o
);
  localparam int RW = $clog2(MIN_LOW + 1);

  logic          sync1_q, sync2_q;
  logic [RW-1:0] run_q;
  logic          low;

  assign low = ~sync2_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      sync1_q  <= 1'b1;
      sync2_q  <= 1'b1;
      run_q    <= '0;
      hw_acc_o <= 1'b0;
    end else begin
      sync1_q <= pin_n_i;
      sync2_q <= sync1_q;
      if (low) begin
        if (int'(run_q) < MIN_LOW) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
      hw_acc_o <= low && (hw_acc_o || (int'(run_q) + 1 >= MIN_LOW));
    end
  end

  // R2
  glitch_reject_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(hw_acc_o) |-> ($past(low) && (int'($past(run_q)) + 1 >= MIN_LOW)));

  // R2
  release_follows_pin_chk: assert property (@(posedge clk_i) disable iff (por_i)
    hw_acc_o |-> $past(low));
endmodule

// File: rtl/xrc_host_regs.sv
module xrc_host_regs
  import xrc_pkg::*;
(
  input  logic                clk_i,
  input  logic                por_i,
  input  logic                clr_i,
  input  logic                we_i,
  input  xrc_addr_t           addr_i,
  input  xrc_word_t           wdata_i,
  output xrc_word_t           rdata_o,
  output logic [XRC_NCH-1:0]  ch_srst_o,
  output logic                glb_srst_o
);
  logic [XRC_NCH-1:0][XRC_DW-1:0] cfg_q;
  xrc_word_t                      glb_q;

  for (genvar c = 0; c < XRC_NCH; c++) begin : g_cfg
    always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i)                                 cfg_q[c] <= '0;
      else if (clr_i)                            cfg_q[c] <= '0;
      else if (we_i && addr_i == XRC_AW'(c))     cfg_q[c] <= wdata_i;
    end
    assign ch_srst_o[c] = cfg_q[c][XRC_SRST_BIT];

    // R6
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
      (!clr_i && !(we_i && addr_i == XRC_AW'(c))) |=> $stable(cfg_q[c]));

    // R3
    cfg_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
      clr_i |=> (cfg_q[c] == '0));
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                                     glb_q <= '0;
    else if (clr_i)                                glb_q <= '0;
    else if (we_i && addr_i == XRC_AW'(XRC_GLB_ADDR)) glb_q <= wdata_i;
  end
  assign glb_srst_o = glb_q[XRC_GLB_BIT];

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < XRC_NCH; c++)
      if (addr_i == XRC_AW'(c)) rdata_o = cfg_q[c];
    if (addr_i == XRC_AW'(XRC_GLB_ADDR)) rdata_o = glb_q;
  end

  // R3
  glb_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
    clr_i |=> (glb_q == '0));
endmodule

// File: rtl/xrc_settle.sv
module xrc_settle #(
  parameter int SETTLE_CYC = 375000
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic hold_i,
  output logic rst_o,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cnt_q   <= '0;
      rst_o   <= 1'b1;
      ready_o <= 1'b0;
    end else if (hold_i) begin
      cnt_q   <= '0;
      rst_o   <= 1'b1;
      ready_o <= 1'b0;
    end else begin
      rst_o <= 1'b0;
      if (!ready_o) begin
        if (cnt_q == CW'(SETTLE_CYC - 1)) ready_o <= 1'b1;
        else                              cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  // R7
  ready_after_release_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(ready_o) |-> $past(!hold_i));

  // R8
  hold_drops_ready_chk: assert property (@(posedge clk_i) disable iff (por_i)
    hold_i |=> (!ready_o && rst_o));

  // R7
  ready_excl_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
    ready_o |-> !rst_o);
endmodule

// File: rtl/xrc_rst_ctrl.sv
module xrc_rst_ctrl
  import xrc_pkg::*;
#(
  parameter int SETTLE_CYC = 375000,
  parameter int MIN_LOW    = 2
) (
  input  logic                clk_i,
  input  logic                por_i,
  input  logic                hw_rst_n_i,
  input  logic                reg_we_i,
  input  logic [XRC_AW-1:0]   reg_addr_i,
  input  logic [XRC_DW-1:0]   reg_wdata_i,
  output logic [XRC_DW-1:0]   reg_rdata_o,
  output logic [XRC_NCH-1:0]  ch_rst_o,
  output logic [XRC_NCH-1:0]  ch_ready_o
);
  logic               hw_acc;
  logic [XRC_NCH-1:0] ch_srst;
  logic               glb_srst;
  logic [XRC_NCH-1:0] hold;

  xrc_pin_filter #(.MIN_LOW(MIN_LOW)) u_pin (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .pin_n_i  (hw_rst_n_i),
    .hw_acc_o (hw_acc)
  );

  xrc_host_regs u_regs (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .clr_i      (hw_acc),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .ch_srst_o  (ch_srst),
    .glb_srst_o (glb_srst)
  );

  for (genvar c = 0; c < XRC_NCH; c++) begin : g_ch
    assign hold[c] = hw_acc | glb_srst | ch_srst[c];

    xrc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk_i   (clk_i),
      .por_i   (por_i),
      .hold_i  (hold[c]),
      .rst_o   (ch_rst_o[c]),
      .ready_o (ch_ready_o[c])
    );

    // R4
    ch_srst_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
      ch_srst[c] |=> ch_rst_o[c]);

    // R5
    glb_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
      glb_srst |=> ch_rst_o[c]);
  end

  // R1
  always_comb begin
    if (por_i) por_outputs_chk: assert (ch_ready_o == '0);
  end
endmodule

// File: tb/test_xrc_rst_ctrl.sv
module test_xrc_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;
  localparam int MINL       = 2;

  logic       clk = 1'b0;
  logic       por, pin_n, we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [3:0] rst, rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  xrc_rst_ctrl #(.SETTLE_CYC(SETTLE), .MIN_LOW(MINL)) i_xrc_rst_ctrl (
    .clk_i(clk), .por_i(por), .hw_rst_n_i(pin_n), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ch_rst_o(rst), .ch_ready_o(rdy)
  );

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit       m_s1 = 1, m_s2 = 1, m_acc = 0;
  int       m_run = 0;
  bit [7:0] m_cfg [4];
  bit [7:0] m_glb = 0;
  int       m_quiet [4];
  bit       m_rst [4];

  always @(posedge clk) begin
    if (por) begin
      m_s1 = 1; m_s2 = 1; m_acc = 0; m_run = 0; m_glb = 0;
      for (int c = 0; c < 4; c++) begin m_cfg[c] = 0; m_quiet[c] = 0; m_rst[c] = 1; end
    end else begin
      bit low, nacc;
      for (int c = 0; c < 4; c++) begin
        if (m_acc || m_glb[0] || m_cfg[c][2]) begin m_rst[c] = 1; m_quiet[c] = 0; end
        else begin m_rst[c] = 0; if (m_quiet[c] < SETTLE) m_quiet[c]++; end
      end
      if (m_acc) begin
        for (int c = 0; c < 4; c++) m_cfg[c] = 0;
        m_glb = 0;
      end else if (we) begin
        if (addr < 4) m_cfg[addr[1:0]] = wdata;
        else if (addr == 4) m_glb = wdata;
      end
      low  = !m_s2;
      nacc = low && (m_acc || (m_run + 1 >= MINL));
      m_run = low ? ((m_run + 1 > MINL) ? MINL : m_run + 1) : 0;
      m_s2 = m_s1; m_s1 = pin_n; m_acc = nacc;
    end
  end

  function automatic logic [7:0] m_read();
    if (por) return 8'h00;
    if (addr < 4) return m_cfg[addr[1:0]];
    if (addr == 4) return m_glb;
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      chk($sformatf("ch%0d rst", c), {7'd0, rst[c]}, {7'd0, por ? 1'b1 : m_rst[c]});
      chk($sformatf("ch%0d ready", c), {7'd0, rdy[c]},
          {7'd0, por ? 1'b0 : (m_quiet[c] >= SETTLE)});
    end
    chk("rdata", rdata, m_read());
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    por = 1'b1; pin_n = 1'b1; we = 1'b0; addr = 3'd0; wdata = 8'h00;
    cur_req = "R1";
    tick(3);
    @(negedge clk); chk("por rdy", {4'd0, rdy}, 8'h00);
    tick(1);
    por = 1'b0;
    cur_req = "R7";
    tick(SETTLE - 1);
    @(negedge clk); chk("ready not yet", {4'd0, rdy}, 8'h00);
    tick(1);
    @(negedge clk); chk("ready set", {4'd0, rdy}, 8'h0F);
    tick(3);

    cur_req = "R4";
    wr(3'd1, 8'h54);
    tick(3);
    @(negedge clk); chk("ch1 only", {4'd0, rst}, 8'h02);
    cur_req = "R6";
    addr = 3'd1;
    @(negedge clk); chk("cfg1 kept", rdata, 8'h54);
    tick(1);
    wr(3'd1, 8'h50);
    cur_req = "R7";
    tick(SETTLE + 3);

    cur_req = "R5";
    wr(3'd4, 8'h01);
    tick(2);
    @(negedge clk); chk("all rst", {4'd0, rst}, 8'h0F);
    cur_req = "R8";
    wr(3'd2, 8'h04);
    tick(2);
    wr(3'd4, 8'h00);
    tick(5);
    wr(3'd3, 8'h04);
    tick(1);
    wr(3'd3, 8'h00);
    tick(SETTLE / 2);
    wr(3'd2, 8'h00);
    tick(SETTLE - 2);
    @(negedge clk); chk("ch2 waits", {7'd0, rdy[2]}, 8'h00);
    tick(4);
    cur_req = "R6";
    addr = 3'd1;
    @(negedge clk); chk("cfg1 after glb", rdata, 8'h50);
    tick(SETTLE);

    cur_req = "R2";
    pin_n = 1'b0; tick(1); pin_n = 1'b1;
    tick(8);
    addr = 3'd1;
    @(negedge clk); chk("glitch regs", rdata, 8'h50);
    chk("glitch rst", {4'd0, rst}, 8'h00);
    tick(2);

    cur_req = "R2";
    pin_n = 1'b0; tick(2); pin_n = 1'b1;
    tick(6);
    cur_req = "R3";
    addr = 3'd1;
    @(negedge clk); chk("two-cycle clears", rdata, 8'h00);
    tick(SETTLE + 2);
    wr(3'd0, 8'h33);
    pin_n = 1'b0; tick(4);
    wr(3'd0, 8'h44);
    tick(2);
    addr = 3'd0;
    @(negedge clk); chk("write blocked", rdata, 8'h00);
    chk("hw rst all", {4'd0, rst}, 8'h0F);
    tick(1);
    pin_n = 1'b1;
    tick(SETTLE + 6);

    cur_req = "R9";
    wr(3'd6, 8'hAA);
    addr = 3'd6;
    @(negedge clk); chk("unmapped", rdata, 8'h00);
    tick(3);
    finish_run();
  end
endmodule